// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an external asynchronous static RAM. The RAM is 16 bits wide, has a 19-bit word address, and uses active-low controls for chip select, write strobe, output enable and the two byte lanes. The host offers one word access at a time on a valid/ready channel. Each access carries an address, a write flag, 16 bits of write data and a 2-bit lane mask. A read answers with a one-cycle response strobe and the returned word.

Every memory pin is driven from a register. Three clock-count parameters set the cycle timing: `RD_CYC` is the number of cycles from address and enables to data sampling, `WP_CYC` is the length of the write strobe, and `TA_CYC` is the number of idle cycles inserted when a write follows a read. Each count is the memory's nanosecond minimum divided by the clock period and rounded up. The data pins appear as a separate output word, an input word and a drive enable; the pad cell itself sits outside the block.

The state machine has six states. `ST_IDLE` accepts requests. `ST_RD_ACC` holds a read open. `ST_TURN` is the idle gap between a read and a write. `ST_WR_SETUP` presents the address with the strobe high. `ST_WR_PULSE` holds the strobe low. `ST_WR_HOLD` ends the write while the data is still driven. The transitions are:
- `ST_IDLE` to `ST_RD_ACC` on a read.
- `ST_IDLE` to `ST_TURN` on a write after a read.
- `ST_IDLE` to `ST_WR_SETUP` on any other write.
- `ST_RD_ACC` to `ST_IDLE` when its count expires.
- `ST_TURN` to `ST_WR_SETUP` when its count expires.
- `ST_WR_SETUP` to `ST_WR_PULSE` always.
- `ST_WR_PULSE` to `ST_WR_HOLD` when its count expires.
- `ST_WR_HOLD` to `ST_IDLE` always.

A request with an all-zero lane mask leaves the state in `ST_IDLE`.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, chip select, write strobe, output enable and both lane selects are high, the data drive enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A read accepted at clock edge E drives chip select and output enable low from E to E+RD_CYC. During that window the write strobe is high, `req_ready` is low and the memory address equals the request address.
- R3: The read data is sampled at edge E+RD_CYC. After that edge, `rsp_valid` is high for exactly one cycle. Chip select, output enable and the lane selects return high at the same edge.
- R4: A write accepted at edge E with no turnaround spends one cycle with chip select low and the strobe high. It then holds the strobe low for WP_CYC cycles while driving the write data. Next comes one cycle with the strobe and chip select high, and the block is ready again after edge E+WP_CYC+2.
- R5: The write strobe is high in the cycle before and the cycle after any change of the memory address.
- R6: The data drive enable is high only while the strobe is low or in the cycle right after it rises. It is never high while output enable is low.
- R7: A write accepted right after a completed read first passes TA_CYC cycles with all controls high and the drive enable low. A write that follows another write gets no such gap.
- R8: `req_ready` is low whenever a cycle is in progress. A request presented while `req_ready` is low has no effect.
- R9: A request whose lane mask is 2'b00 causes no memory activity. As a write, it leaves memory unchanged and the block stays ready. As a read, it returns `rsp_valid` one cycle after acceptance with data 16'h0000.
- R10: Lane mask bit 0 enables data bits 7:0 through the lower lane select, and bit 1 enables bits 15:8 through the upper lane select. A read returns zero in any lane whose mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask (bit 0 low byte, bit 1 high byte) |
| rsp_valid | output | 1 | One-cycle read completion strobe |
| rsp_rdata | output | 16 | Read data, zero in unselected lanes |
| sram_addr | output | 19 | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lb_n | output | 1 | Lower lane select, active low |
| sram_ub_n | output | 1 | Upper lane select, active low |
| sram_dq_out | output | 16 | Data toward the memory |
| sram_dq_oe | output | 1 | Drive enable for the data pins |
| sram_dq_in | input | 16 | Data from the memory |

## Verification
The bench runs a table of reads and writes against a small memory model. The table covers full-word, low-lane-only and high-lane-only writes, which show that each lane select reaches the correct half of the word. Reads with partial masks show that masking zeroes the right half. Zero-mask requests show that neither memory nor the bus is touched. Directed sequences count pin cycles for a read, a write after a write and a write after a read, which tells an inserted turnaround apart from a missing one. A request held up while the block is busy must leave no trace in memory.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } sram_state_e;
endpackage

// File: rtl/sram_wait_timer.sv
// Down counter shared by all timed states; expired is high when the count is zero.
module sram_wait_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expired = (count_q == '0);
endmodule

// File: rtl/sram_lane_mask.sv
// Zeroes every byte lane of the read word whose enable bit is clear.
module sram_lane_mask #(
    parameter int LANES = 2
) (
    input  logic [LANES*8-1:0] din,
    input  logic [LANES-1:0]   lane_en,
    output logic [LANES*8-1:0] dout
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*8 +: 8] = lane_en[g] ? din[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int RD_CYC = 9,
    parameter int WP_CYC = 5,
    parameter int TA_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_be,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic              sram_lb_n,
    output logic              sram_ub_n,
    output logic [15:0]       sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [15:0]       sram_dq_in
);
    localparam int LANES    = 2;
    localparam int MAX_A    = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
    localparam int MAX_WAIT = (MAX_A > TA_CYC) ? MAX_A : TA_CYC;
    localparam int TW       = $clog2(MAX_WAIT + 1);

    sram_state_e      state_q, state_d;
    logic             last_rd_q;
    logic [15:0]      wdata_q;
    logic [LANES-1:0] be_q;
    logic [15:0]      lane_data;
    logic             tmr_load;
    logic [TW-1:0]    tmr_val;
    logic             tmr_done;
    logic             accept;
    logic             mask_empty;

    assign req_ready  = (state_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign mask_empty = (req_be == '0);

    sram_wait_timer #(.CW(TW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    sram_lane_mask #(.LANES(LANES)) mask_i (
        .din     (sram_dq_in),
        .lane_en (be_q),
        .dout    (lane_data)
    );

    // next state and timer loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !mask_empty) begin
                    if (!req_write) begin
                        state_d  = ST_RD_ACC;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(RD_CYC - 1);
                    end else if (last_rd_q) begin
                        state_d  = ST_TURN;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(TA_CYC - 1);
                    end else begin
                        state_d  = ST_WR_SETUP;
                    end
                end
            end
            ST_RD_ACC:   if (tmr_done) state_d = ST_IDLE;
            ST_TURN:     if (tmr_done) state_d = ST_WR_SETUP;
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = TW'(WP_CYC - 1);
            end
            ST_WR_PULSE: if (tmr_done) state_d = ST_WR_HOLD;
            ST_WR_HOLD:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered pins and host outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sram_addr   <= '0;
            sram_ce_n   <= 1'b1;
            sram_we_n   <= 1'b1;
            sram_oe_n   <= 1'b1;
            sram_lb_n   <= 1'b1;
            sram_ub_n   <= 1'b1;
            sram_dq_out <= '0;
            sram_dq_oe  <= 1'b0;
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
            wdata_q     <= '0;
            be_q        <= '0;
            last_rd_q   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        sram_addr <= req_addr;
                        wdata_q   <= req_wdata;
                        be_q      <= req_be;
                        if (mask_empty) begin
                            if (!req_write) begin
                                rsp_valid <= 1'b1;
                                rsp_rdata <= '0;
                            end
                        end else if (!req_write) begin
                            sram_ce_n <= 1'b0;
                            sram_oe_n <= 1'b0;
                            sram_lb_n <= ~req_be[0];
                            sram_ub_n <= ~req_be[1];
                        end else begin
                            last_rd_q <= 1'b0;
                            if (!last_rd_q) begin
                                sram_ce_n <= 1'b0;
                                sram_lb_n <= ~req_be[0];
                                sram_ub_n <= ~req_be[1];
                            end
                        end
                    end
                end
                ST_RD_ACC: begin
                    if (tmr_done) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= lane_data;
                        sram_ce_n <= 1'b1;
                        sram_oe_n <= 1'b1;
                        sram_lb_n <= 1'b1;
                        sram_ub_n <= 1'b1;
                        last_rd_q <= 1'b1;
                    end
                end
                ST_TURN: begin
                    if (tmr_done) begin
                        sram_ce_n <= 1'b0;
                        sram_lb_n <= ~be_q[0];
                        sram_ub_n <= ~be_q[1];
                    end
                end
                ST_WR_SETUP: begin
                    sram_we_n   <= 1'b0;
                    sram_dq_oe  <= 1'b1;
                    sram_dq_out <= wdata_q;
                end
                ST_WR_PULSE: begin
                    if (tmr_done) begin
                        sram_we_n <= 1'b1;
                        sram_ce_n <= 1'b1;
                    end
                end
                ST_WR_HOLD: begin
                    sram_dq_oe <= 1'b0;
                    sram_lb_n  <= 1'b1;
                    sram_ub_n  <= 1'b1;
                end
                default: begin
                    sram_ce_n <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              sram_lb_n,
    input logic              sram_ub_n,
    input logic              sram_dq_oe
);
    a_r5_we_high_on_addr_change: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_addr != $past(sram_addr)) |-> (sram_we_n && $past(sram_we_n)));

    a_r6_no_drive_during_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_dq_oe && !sram_oe_n));

    a_r6_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (!sram_we_n || !$past(sram_we_n)));

    a_r2_read_controls: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_ce_n && sram_we_n));

    a_r4_strobe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> (!sram_ce_n && sram_oe_n));

    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce_n |-> !req_ready);

    a_r10_lane_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce_n |-> !(sram_lb_n && sram_ub_n));
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .sram_addr  (sram_addr),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_lb_n  (sram_lb_n),
    .sram_ub_n  (sram_ub_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_cycle_ctrl_tb_top.sv
module sram_cycle_ctrl_tb_top;
    localparam int RD = 9;
    localparam int WP = 5;
    localparam int TA = 4;
    localparam int NV = 12;

    // {write, addr, wdata, be, expected read data}
    localparam logic [53:0] VEC [NV] = '{
        {1'b1, 19'h40001, 16'h1234, 2'b11, 16'h0000},
        {1'b1, 19'h00002, 16'hABCD, 2'b11, 16'h0000},
        {1'b0, 19'h40001, 16'h0000, 2'b11, 16'h1234},
        {1'b0, 19'h00002, 16'h0000, 2'b01, 16'h00CD},
        {1'b1, 19'h7FFF1, 16'h55AA, 2'b10, 16'h0000},
        {1'b0, 19'h00001, 16'h0000, 2'b11, 16'h5534},
        {1'b0, 19'h00002, 16'h0000, 2'b10, 16'hAB00},
        {1'b1, 19'h00003, 16'hFFFF, 2'b01, 16'h0000},
        {1'b0, 19'h00003, 16'h0000, 2'b11, 16'h00FF},
        {1'b1, 19'h00004, 16'hC0DE, 2'b00, 16'h0000},
        {1'b0, 19'h00004, 16'h0000, 2'b11, 16'h0000},
        {1'b0, 19'h00002, 16'h0000, 2'b00, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [18:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, sram_dq_oe;
    logic [15:0] sram_dq_out, sram_dq_in;

    int checks = 0;
    int errors = 0;

    logic [15:0] mem [16];
    logic        pend = 1'b0;
    logic [15:0] pend_d;
    logic [3:0]  pend_a;
    logic [1:0]  pend_l;

    always #4 clk = ~clk;

    sram_cycle_ctrl #(.ADDR_W(19), .RD_CYC(RD), .WP_CYC(WP), .TA_CYC(TA)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    // memory model: word stored when the strobe ends
    assign sram_dq_in = mem[sram_addr[3:0]];

    always @(negedge clk) begin
        if (!sram_ce_n && !sram_we_n) begin
            pend   = 1'b1;
            pend_d = sram_dq_out;
            pend_a = sram_addr[3:0];
            pend_l = {~sram_ub_n, ~sram_lb_n};
        end else if (pend) begin
            if (pend_l[0]) mem[pend_a][7:0]  = pend_d[7:0];
            if (pend_l[1]) mem[pend_a][15:8] = pend_d[15:8];
            pend = 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // issue at a negedge; returns at the negedge of completion
    task automatic do_op(input logic wr, input logic [18:0] a, input logic [15:0] d,
                         input logic [1:0] be, output logic [15:0] rd);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        rd = 16'hxxxx;
        for (int n = 0; n < 40; n++) begin
            if (!wr && rsp_valid) begin
                rd = rsp_rdata;
                break;
            end
            if (wr && req_ready) break;
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 20000);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        for (int i = 0; i < 16; i++) mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", {sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n}, 5'b11111);
        chk("R1 hs", {sram_dq_oe, req_ready, rsp_valid}, 3'b010);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R3 R9 R10
        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][53], VEC[i][52:34], VEC[i][33:18], VEC[i][17:16], rd);
            if (!VEC[i][53]) chk($sformatf("R10 vec%0d rdata", i), rd, VEC[i][15:0]);
        end

        // R7 write after read gets turnaround
        do_op(1'b0, 19'h00001, 16'h0, 2'b11, rd);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00006; req_wdata = 16'h0F0F; req_be = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= TA; k++) begin
            chk("R7 turn ctrl", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready}, 5'b11100);
            @(negedge clk);
        end
        chk("R7 setup after turn", {sram_ce_n, sram_we_n}, 2'b01);
        @(negedge clk);
        chk("R7 strobe after turn", {sram_we_n, sram_dq_oe}, 2'b01);
        while (!req_ready) @(negedge clk);

        // R4 R6 write after write, no turnaround
        req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00007; req_wdata = 16'hBEEF; req_be = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R4 setup", {sram_ce_n, sram_we_n, sram_dq_oe, req_ready}, 4'b0100);
        chk("R4 addr", sram_addr, 19'h00007);
        @(negedge clk);
        for (int k = 0; k < WP; k++) begin
            chk("R4 strobe", {sram_ce_n, sram_we_n, sram_dq_oe}, 3'b001);
            chk("R6 dq_out", sram_dq_out, 16'hBEEF);
            @(negedge clk);
        end
        chk("R4 hold", {sram_ce_n, sram_we_n, sram_dq_oe, req_ready}, 4'b1110);
        @(negedge clk);
        chk("R6 release", {sram_dq_oe, req_ready}, 2'b01);

        // R2 R3 R8 R10 read timing with an intruding request
        req_valid = 1'b1; req_write = 1'b0; req_addr = 19'h00007; req_be = 2'b01;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= RD; k++) begin
            chk("R2 read ctrl", {sram_ce_n, sram_oe_n, sram_we_n, req_ready}, 4'b0010);
            chk("R10 lanes", {sram_ub_n, sram_lb_n}, 2'b10);
            chk("R2 addr", sram_addr, 19'h00007);
            if (k == 2) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00005;
                req_wdata = 16'h9999; req_be = 2'b11;
            end
            if (k == RD) req_valid = 1'b0;
            @(negedge clk);
        end
        chk("R3 rsp", {rsp_valid, sram_ce_n, sram_oe_n, sram_lb_n}, 4'b1111);
        chk("R3 data", rsp_rdata, 16'h00EF);
        @(negedge clk);
        chk("R3 one pulse", rsp_valid, 1'b0);
        do_op(1'b0, 19'h00005, 16'h0, 2'b11, rd);
        chk("R8 ignored write", rd, 16'h0000);

        // R9 zero lane mask
        req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00007; req_wdata = 16'h0000; req_be = 2'b00;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 write idle", {sram_ce_n, sram_we_n, sram_dq_oe, req_ready}, 4'b1101);
        repeat (2) @(negedge clk);
        do_op(1'b0, 19'h00007, 16'h0, 2'b11, rd);
        chk("R9 memory kept", rd, 16'hBEEF);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 19'h00007; req_be = 2'b00;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 read rsp", {rsp_valid, sram_ce_n, sram_oe_n}, 3'b111);
        chk("R9 read data", rsp_rdata, 16'h0000);

        finish_run();
    end
endmodule